// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between synchronous logic and an asynchronous static RAM that has a chip select, a semaphore select, a read/write line, an output enable and separate upper and lower byte strobes. Each request carries an address, a 16-bit data word, two byte enables, a flag that picks the RAM array or the semaphore space, and two mode flags. The block turns one accepted request into one complete write cycle on the memory pins. Every interval of that cycle is a whole number of clock cycles set by a parameter.

Two strobe modes are supported. In the first mode the read/write line times the write. The select and the byte strobes open the cycle, and the read/write line pulses low inside them. If the requester asks for output enable to stay low, the pulse is lengthened, and the data drivers wait until the memory outputs have had time to float. In the second mode the select times the write. Read/write falls first and the select falls one cycle later, so the memory outputs stay in high impedance throughout. Output enable is held high for the whole cycle.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, req_ready is 1, mem_ce_n, mem_sem_n, mem_rw_n, mem_oe_n, mem_ub_n and mem_lb_n are all 1, and mem_dq_oe is 0.
- R2: A request is taken at a rising edge where req_valid and req_ready are both 1. req_ready is then 0 for B cycles, where B = max(T_WC-1, T_SA + A + P + H). A is 1 in select-strobed mode and 0 otherwise. P is the strobe length from R6/R7. H = max(T_HD, T_HA). A request presented while req_ready is 0 is not taken.
- R3: mem_addr changes only at the edge that takes a request, and it takes that request's address. mem_rw_n is 1 in the cycles on both sides of any change of mem_addr.
- R4: When req_sem is 0 (RAM), the active select is mem_ce_n low with mem_sem_n high. When req_sem is 1 (semaphore), mem_sem_n is low with mem_ce_n high. The two selects are never low together.
- R5: mem_ub_n is low exactly when the select is active and req_be[1] is set. mem_lb_n is low exactly when the select is active and req_be[0] is set. req_be[1] covers data bits 15:8 and req_be[0] covers bits 7:0.
- R6: With req_ce_strobe = 0, the select and the byte strobes are low for T_SA + P + H cycles, starting in the cycle after acceptance. mem_rw_n is low for P cycles starting T_SA cycles after that. P = max(T_PWE, T_HZWE+T_SD) when req_oe_low = 1, and P = max(T_PWE, T_SD) otherwise.
- R7: With req_ce_strobe = 1, mem_rw_n goes low T_SA cycles after acceptance. The select and the byte strobes go low one cycle later for P = max(T_PWE, T_SD) cycles. mem_rw_n stays low for H more cycles after the select goes back high.
- R8: mem_oe_n is low through the busy cycles only when req_ce_strobe = 0 and req_oe_low = 1. Otherwise it is 1.
- R9: mem_dq_oe turns on T_HZWE cycles into the strobe in the output-enable-low read/write mode, and at the start of the strobe in every other mode. It stays on for T_HD cycles after the strobe ends. While it is on, mem_dq_out carries the accepted data. The drive therefore covers at least T_SD cycles before the strobe ends.
- R10: While the block is busy, req_valid and the request fields have no effect on mem_addr, mem_dq_out or any strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, able to take a request |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data word |
| req_be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| req_sem | input | 1 | 1 selects semaphore space, 0 selects RAM |
| req_ce_strobe | input | 1 | 1 times the write with the select, 0 with read/write |
| req_oe_low | input | 1 | Keep output enable low during a read/write-timed write |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data to drive onto the memory bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_sem_n | output | 1 | Semaphore select, active low |
| mem_rw_n | output | 1 | Read/write line, low writes |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |

## Verification
The bench targets the lengthened pulse with output enable low. A design that used the short pulse there, or drove data at once, would show mem_rw_n rising one cycle early and mem_dq_oe rising two cycles early. In select-strobed mode it checks that read/write falls a full cycle before the select. A design that swapped the order would let the memory outputs switch on against the driven bus. It also sends back-to-back requests and keeps requests arriving while the block is busy, so a design that accepted early or let the address move while read/write was low would break the cycle-time window or corrupt the write.

// File: rtl/sram_wr_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the SRAM write sequencer.
// Assumes nothing beyond elaboration-time integer parameters.
package sram_wr_pkg;

    // Phases of one write cycle, in the order they occur.
    typedef enum logic [2:0] {
        PH_IDLE,   // waiting for a request
        PH_ASU,    // address setup
        PH_ARM,    // select-strobed mode only: read/write low ahead of select
        PH_STRB,   // write strobe active
        PH_HOLD,   // data and address hold after the strobe
        PH_REC     // padding until the cycle time is met
    } phase_e;

    // Larger of two integers, for parameter arithmetic.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wr_cnt.sv
`timescale 1ns/1ps
// Saturating up-counter with synchronous clear.
// Assumes W is wide enough that saturation is never reached while timing.
module sram_wr_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    // Count cycles since the last clear, stopping at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (clr)           cnt <= '0;
        else if (cnt != '1)     cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sram_wr_ctl.sv
`timescale 1ns/1ps
// Phase sequencer: captures a request and steps through the write phases.
// Assumes all timing parameters are at least 1 (T_HD may be 0), T_WC >= 2,
// and CW large enough to count one full cycle.
module sram_wr_ctl
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int T_SA   = 2,
    parameter int T_PWE  = 3,
    parameter int T_HZWE = 2,
    parameter int T_SD   = 2,
    parameter int T_HD   = 2,
    parameter int T_HA   = 1,
    parameter int T_WC   = 9,
    parameter int CW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [1:0]        req_be,
    input  logic              req_sem,
    input  logic              req_ce_strobe,
    input  logic              req_oe_low,
    input  logic [CW-1:0]     pcnt,
    input  logic [CW-1:0]     ccnt,
    output phase_e            phase,
    output logic              accept,
    output logic              step,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_data,
    output logic [1:0]        lat_be,
    output logic              lat_sem,
    output logic              lat_ce,
    output logic              lat_oe
);

    localparam int P_HI      = imax(T_PWE, T_SD);
    localparam int P_LO      = imax(T_PWE, T_HZWE + T_SD);
    localparam int H_LEN     = imax(T_HD, T_HA);
    localparam logic [CW-1:0] ASU_LAST  = CW'(T_SA - 1);
    localparam logic [CW-1:0] HI_LAST   = CW'(P_HI - 1);
    localparam logic [CW-1:0] LO_LAST   = CW'(P_LO - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(H_LEN - 1);
    localparam logic [CW-1:0] CYC_LAST  = CW'(imax(T_WC - 2, 0));

    phase_e            nxt;
    logic [CW-1:0]     strb_last;

    // Pick the strobe length: stretched only for read/write timing with OE low.
    always_comb strb_last = (!lat_ce && lat_oe) ? LO_LAST : HI_LAST;

    // Take a request only from the idle phase.
    always_comb accept = (phase == PH_IDLE) && req_valid;

    // Next-phase decision from the phase counter and the cycle counter.
    always_comb begin
        nxt = phase;
        case (phase)
            PH_IDLE: if (req_valid)              nxt = PH_ASU;
            PH_ASU:  if (pcnt == ASU_LAST)       nxt = lat_ce ? PH_ARM : PH_STRB;
            PH_ARM:                              nxt = PH_STRB;
            PH_STRB: if (pcnt == strb_last)      nxt = PH_HOLD;
            PH_HOLD: if (pcnt == HOLD_LAST)      nxt = (ccnt >= CYC_LAST) ? PH_IDLE : PH_REC;
            PH_REC:  if (ccnt >= CYC_LAST)       nxt = PH_IDLE;
            default:                             nxt = PH_IDLE;
        endcase
    end

    // Restart the phase counter on every phase change.
    always_comb step = (nxt != phase);

    // Phase register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            lat_addr <= '0;
            lat_data <= '0;
            lat_be   <= '0;
            lat_sem  <= 1'b0;
            lat_ce   <= 1'b0;
            lat_oe   <= 1'b0;
        end else begin
            phase <= nxt;
            if (accept) begin
                lat_addr <= req_addr;
                lat_data <= req_data;
                lat_be   <= req_be;
                lat_sem  <= req_sem;
                lat_ce   <= req_ce_strobe;
                lat_oe   <= req_oe_low;
            end
        end
    end

endmodule

// File: rtl/sram_wr_seq.sv
`timescale 1ns/1ps
// Top of the SRAM write sequencer: one accepted request becomes one write
// cycle on the memory pins, timed in whole clock cycles.
// Assumes a single requester and that the pins are registered or short paths;
// the pin levels are decoded from flops only, never from request inputs.
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int T_SA   = 2,
    parameter int T_PWE  = 3,
    parameter int T_HZWE = 2,
    parameter int T_SD   = 2,
    parameter int T_HD   = 2,
    parameter int T_HA   = 1,
    parameter int T_WC   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [1:0]        req_be,
    input  logic              req_sem,
    input  logic              req_ce_strobe,
    input  logic              req_oe_low,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_sem_n,
    output logic              mem_rw_n,
    output logic              mem_oe_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n
);

    localparam int P_LO  = imax(T_PWE, T_HZWE + T_SD);
    localparam int H_LEN = imax(T_HD, T_HA);
    localparam int CW    = $clog2(T_SA + 1 + P_LO + H_LEN + T_WC + 2);
    localparam logic [CW-1:0] HZ_OFF  = CW'(T_HZWE);
    localparam logic [CW-1:0] HD_CNT  = CW'(T_HD);

    phase_e            phase;
    logic              accept, step;
    logic [CW-1:0]     pcnt, ccnt, doff;
    logic [1:0]        lat_be;
    logic              lat_sem, lat_ce, lat_oe;
    logic              busy, sel_on, rw_low;

    sram_wr_ctl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_SA(T_SA), .T_PWE(T_PWE),
        .T_HZWE(T_HZWE), .T_SD(T_SD), .T_HD(T_HD), .T_HA(T_HA),
        .T_WC(T_WC), .CW(CW)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
        .req_sem(req_sem), .req_ce_strobe(req_ce_strobe),
        .req_oe_low(req_oe_low), .pcnt(pcnt), .ccnt(ccnt),
        .phase(phase), .accept(accept), .step(step),
        .lat_addr(mem_addr), .lat_data(mem_dq_out), .lat_be(lat_be),
        .lat_sem(lat_sem), .lat_ce(lat_ce), .lat_oe(lat_oe)
    );

    sram_wr_cnt #(.W(CW)) u_phase_cnt (
        .clk(clk), .rst_n(rst_n), .clr(step), .cnt(pcnt)
    );

    sram_wr_cnt #(.W(CW)) u_cycle_cnt (
        .clk(clk), .rst_n(rst_n), .clr(accept), .cnt(ccnt)
    );

    // Busy whenever a write cycle is in progress.
    always_comb busy = (phase != PH_IDLE);
    always_comb req_ready = !busy;

    // Select window and read/write window, by strobe mode.
    always_comb begin
        if (lat_ce) begin
            sel_on = (phase == PH_STRB);
            rw_low = (phase == PH_ARM) || (phase == PH_STRB) || (phase == PH_HOLD);
        end else begin
            sel_on = (phase == PH_ASU) || (phase == PH_STRB) || (phase == PH_HOLD);
            rw_low = (phase == PH_STRB);
        end
    end

    // Control pins, active low.
    always_comb begin
        mem_ce_n  = !(sel_on && !lat_sem);
        mem_sem_n = !(sel_on && lat_sem);
        mem_ub_n  = !(sel_on && lat_be[1]);
        mem_lb_n  = !(sel_on && lat_be[0]);
        mem_rw_n  = !rw_low;
        mem_oe_n  = !(busy && !lat_ce && lat_oe);
    end

    // Data drive window: delayed for float time when OE is low, held after strobe.
    always_comb doff = (!lat_ce && lat_oe) ? HZ_OFF : '0;
    always_comb mem_dq_oe = ((phase == PH_STRB) && (pcnt >= doff)) ||
                            ((phase == PH_HOLD) && (pcnt < HD_CNT));

endmodule

// File: rtl/sram_wr_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for the SRAM write sequencer, bound to its ports.
// Assumes synchronous active-low reset; run-length counters replace long $past.
module sram_wr_seq_chk #(
    parameter int ADDR_W = 12,
    parameter int T_SD   = 2,
    parameter int T_HZWE = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe,
    input logic              mem_ce_n,
    input logic              mem_sem_n,
    input logic              mem_rw_n,
    input logic              mem_oe_n,
    input logic              mem_ub_n,
    input logic              mem_lb_n
);

    logic [15:0] drv_run, rwl_run;
    logic        wr_act;

    // A write is in effect while select, a byte strobe and read/write low overlap.
    always_comb wr_act = !(mem_ce_n && mem_sem_n) && !(mem_ub_n && mem_lb_n) && !mem_rw_n;

    // Count consecutive cycles of data drive and of read/write low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_run <= '0;
            rwl_run <= '0;
        end else begin
            drv_run <= mem_dq_oe ? ((drv_run == 16'hFFFF) ? drv_run : drv_run + 16'd1) : 16'd0;
            rwl_run <= !mem_rw_n ? ((rwl_run == 16'hFFFF) ? rwl_run : rwl_run + 16'd1) : 16'd0;
        end
    end

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2

    AST_ADDR_MOVES_RW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> (mem_rw_n && $past(mem_rw_n))); // R3

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> mem_sem_n); // R4

    AST_BYTE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ub_n || !mem_lb_n) |-> (!mem_ce_n || !mem_sem_n)); // R5

    AST_OE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(mem_oe_n)); // R8

    AST_FLOAT_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && !mem_oe_n && !mem_rw_n) |-> (rwl_run >= 16'(T_HZWE))); // R9

    AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_act) |-> ($past(mem_dq_oe) && ($past(drv_run) + 16'd1 >= 16'(T_SD)))); // R9

endmodule

bind sram_wr_seq sram_wr_seq_chk #(
    .ADDR_W(ADDR_W), .T_SD(T_SD), .T_HZWE(T_HZWE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n),
    .mem_sem_n(mem_sem_n), .mem_rw_n(mem_rw_n), .mem_oe_n(mem_oe_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n)
);

// File: tb/sram_wr_seq_test.sv
`timescale 1ns/1ps
// Bench: a behavioural cycle model predicts every pin; compared each cycle.
module sram_wr_seq_test;

    localparam int AW = 12, DW = 16;
    localparam int TSA = 2, TPWE = 3, THZ = 2, TSD = 2, THD = 2, THA = 1, TWC = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [1:0] req_be = '0;
    logic req_sem = 1'b0, req_ce_strobe = 1'b0, req_oe_low = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic mem_dq_oe, mem_ce_n, mem_sem_n, mem_rw_n, mem_oe_n, mem_ub_n, mem_lb_n;

    always #2.5 clk = ~clk;

    sram_wr_seq #(
        .ADDR_W(AW), .DATA_W(DW), .T_SA(TSA), .T_PWE(TPWE), .T_HZWE(THZ),
        .T_SD(TSD), .T_HD(THD), .T_HA(THA), .T_WC(TWC)
    ) uut (.*);

    int checks = 0, errors = 0;
    bit run_chk = 0, noise = 0;

    // Reference model state.
    bit m_busy = 0, m_took = 0;
    int m_k = 0, m_B = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;
    logic [1:0] m_be = '0;
    bit m_sem = 0, m_ce = 0, m_oe = 0;

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int strobe_len(input bit ce, input bit oe);
        return (!ce && oe) ? mx(TPWE, THZ + TSD) : mx(TPWE, TSD);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Model: take a request when idle, count cycles while busy.
    always @(posedge clk) begin
        m_took = 0;
        if (!rst_n) begin
            m_busy = 0; m_k = 0; m_addr = '0; m_data = '0; m_be = '0;
            m_sem = 0; m_ce = 0; m_oe = 0;
        end else if (m_busy) begin
            m_k++;
            if (m_k >= m_B) m_busy = 0;
        end else if (req_valid) begin
            m_addr = req_addr; m_data = req_data; m_be = req_be;
            m_sem = req_sem; m_ce = req_ce_strobe; m_oe = req_oe_low;
            m_k = 0; m_busy = 1; m_took = 1;
            m_B = mx(TWC - 1, TSA + (m_ce ? 1 : 0) + strobe_len(m_ce, m_oe) + mx(THD, THA));
        end
    end

    // Compare every pin against the model, away from the rising edge.
    int s0, s1, s2, off;
    bit e_sel, e_rw, e_drv, e_oe;
    string t_rw;
    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            s0 = TSA + (m_ce ? 1 : 0);
            s1 = s0 + strobe_len(m_ce, m_oe);
            s2 = s1 + mx(THD, THA);
            off = (!m_ce && m_oe) ? THZ : 0;
            if (m_busy) begin
                e_sel = m_ce ? (m_k >= s0 && m_k < s1) : (m_k < s2);
                e_rw  = m_ce ? (m_k >= TSA && m_k < s2) : (m_k >= s0 && m_k < s1);
                e_drv = (m_k >= s0 + off && m_k < s1) || (m_k >= s1 && m_k < s1 + THD);
                e_oe  = !m_ce && m_oe;
            end else begin
                e_sel = 0; e_rw = 0; e_drv = 0; e_oe = 0;
            end
            t_rw = m_ce ? "R7" : "R6";
            chk(req_ready == !m_busy, noise ? "R10" : "R2", "req_ready", req_ready, !m_busy);
            chk(mem_addr == m_addr, noise ? "R10" : "R3", "mem_addr", mem_addr, m_addr);
            chk(mem_ce_n == !(e_sel && !m_sem), "R4", "mem_ce_n", mem_ce_n, !(e_sel && !m_sem));
            chk(mem_sem_n == !(e_sel && m_sem), "R4", "mem_sem_n", mem_sem_n, !(e_sel && m_sem));
            chk(mem_ub_n == !(e_sel && m_be[1]), "R5", "mem_ub_n", mem_ub_n, !(e_sel && m_be[1]));
            chk(mem_lb_n == !(e_sel && m_be[0]), "R5", "mem_lb_n", mem_lb_n, !(e_sel && m_be[0]));
            chk(mem_rw_n == !e_rw, t_rw, "mem_rw_n", mem_rw_n, !e_rw);
            chk(mem_oe_n == !e_oe, "R8", "mem_oe_n", mem_oe_n, !e_oe);
            chk(mem_dq_oe == e_drv, "R9", "mem_dq_oe", mem_dq_oe, e_drv);
            if (e_drv)
                chk(mem_dq_out == m_data, noise ? "R10" : "R9", "mem_dq_out", mem_dq_out, m_data);
        end
    end

    // Present one request and hold it until the model reports it taken.
    task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be,
                        input bit sem, input bit ce, input bit oe);
        @(negedge clk); #1;
        req_addr = a; req_data = d; req_be = be;
        req_sem = sem; req_ce_strobe = ce; req_oe_low = oe; req_valid = 1'b1;
        forever begin
            @(posedge clk); #1;
            if (m_took) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic wait_idle;
        while (m_busy) begin @(posedge clk); #1; end
        repeat (2) @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        // R1: reset values, held in reset and just after release.
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(mem_ce_n && mem_sem_n, "R1", "selects", {mem_ce_n, mem_sem_n}, 3);
        chk(mem_rw_n == 1'b1, "R1", "mem_rw_n", mem_rw_n, 1);
        chk(mem_oe_n == 1'b1, "R1", "mem_oe_n", mem_oe_n, 1);
        chk(mem_ub_n && mem_lb_n, "R1", "byte strobes", {mem_ub_n, mem_lb_n}, 3);
        chk(mem_dq_oe == 1'b0, "R1", "mem_dq_oe", mem_dq_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_rw_n && mem_ce_n && mem_sem_n && !mem_dq_oe, "R1",
            "post-reset idle", {req_ready, mem_rw_n, mem_ce_n, mem_sem_n, mem_dq_oe}, 5'b11110);
        run_chk = 1;

        // R6: read/write-timed, OE high, full word to RAM.
        send(12'h0A5, 16'h1234, 2'b11, 0, 0, 0); wait_idle();
        // R6, R8, R9: read/write-timed, OE low, stretched pulse, upper byte only.
        send(12'h3C1, 16'hBEEF, 2'b10, 0, 0, 1); wait_idle();
        // R7, R4: select-timed, semaphore, lower byte; OE request ignored.
        send(12'h7FE, 16'h5A5A, 2'b01, 1, 1, 1); wait_idle();
        // R7: select-timed RAM write, full word.
        send(12'h111, 16'hC0DE, 2'b11, 0, 1, 0); wait_idle();
        // R2, R3: back-to-back requests across modes, held valid while busy.
        send(12'h200, 16'h0F0F, 2'b11, 0, 0, 1);
        send(12'h201, 16'hF0F0, 2'b01, 1, 0, 0);
        send(12'h202, 16'hAAAA, 2'b10, 0, 1, 1);
        wait_idle();
        // R10: requests arriving mid-cycle must not disturb the write.
        send(12'h355, 16'h7777, 2'b11, 0, 0, 1);
        noise = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            req_valid = 1'b1; req_addr = 12'hFFF - 12'(i); req_data = 16'hDEAD;
            req_be = 2'b01; req_sem = 1'b1; req_ce_strobe = 1'b1; req_oe_low = 1'b0;
        end
        @(negedge clk); #1;
        req_valid = 1'b0;
        wait_idle();
        noise = 0;
        repeat (4) @(posedge clk);
        #1;
        finish_run();
    end

endmodule